// File: doc/BRIEF.md
# Interrupt Controller Configuration Register Block

This block is the software-visible register file of an interrupt controller. It decodes a 0x600-byte window on a simple little-endian bus that carries byte and halfword transfers. It keeps the configuration that the source detect and arbitration logic consume: per-source request enables, per-source transfer-trigger enables, priority levels, pin trigger modes, DMA start-source selections, the fast-interrupt vector and its enable, and the non-maskable interrupt enables and mode. It also turns software writes into two kinds of one-cycle strobe. One clears a pending source flag. The other raises a software interrupt.

A bus master drives `addr_i`, `half_i` and `wdata_i`, and pulses `wr_en_i` or `rd_en_i` for one cycle per access. Read data is registered. It appears on `rdata_o` in the cycle after the read strobe and holds there until the next read. Each register accepts exactly one access width. A transfer of the wrong width, or a transfer to a hole in the map, returns all ones on a read and changes nothing on a write. The per-source flags belong to the detect block. They enter on `flag_i` only so that software can read them.

Top module: `icu_reg_if`

## Requirements
- R1: During and after reset every enable, transfer enable, priority, DMA source, fast-interrupt field, NMI enable, NMI mode and `rdata_o` is 0, and every pin trigger mode is 2'b10 (rising edge).
- R2: A read strobe loads `rdata_o` at the next clock edge, and `rdata_o` keeps its value in every cycle that follows a cycle without a read strobe.
- R3: The fast-interrupt register at 0x2F0 accepts only halfword transfers (`half_i`=1), and every other register accepts only byte transfers (`half_i`=0). A wrong-width read returns 16'hFFFF and a wrong-width write changes nothing.
- R4: Addresses outside the map read as 16'hFFFF and ignore writes. This includes 0x220..0x2DF, priority offsets from 0x90 upward, DMA offsets that are not a multiple of 4, and everything from 0x600 upward.
- R5: The byte at 0x200+k (k<32) holds the request enables of sources 8k..8k+7, with bit b driving `src_en_o[8k+b]`. It reads back as written.
- R6: Byte 0x100+n stores only bit 0 as the transfer enable of source n and reads back in bit 0 alone. Byte 0x000+n reads `flag_i[n]` in bit 0, with the other bits 0.
- R7: A byte write of 8'h00 to 0x000+n raises `flag_clr_o[n]` alone, for exactly the cycle after the write. A nonzero value raises nothing.
- R8: Byte 0x300+n (n<144) keeps bits [3:0] as the priority of group n on `prio_o[4n+:4]`. Reads return those bits with bits [7:4] as 0.
- R9: The halfword at 0x2F0 keeps the vector in bits [7:0] and the enable in bit 15. It reads back with bits [14:8] as 0.
- R10: Bytes 0x400, 0x404, 0x408 and 0x40C hold DMA start-source numbers 0..3 on `dma_src_o[8k+:8]`, and they read back as written.
- R11: Byte 0x500+p (p<32) keeps the trigger mode of pin p from bits [3:2] (00 level, 01 falling, 10 rising, 11 both) on `pin_mode_o[2p+:2]`. It reads back as mode<<2.
- R12: A byte write to 0x2E0 with bit 0 set raises `sw_pulse_o` for exactly the next cycle. Reads of 0x2E0 return 0.
- R13: A write to 0x581 ORs bits [2:0] into the NMI enables, which software can never clear. 0x581 reads the enables, and 0x580 and 0x582 read 0 and ignore writes.
- R14: Bit 3 of 0x583 is the NMI mode. Writes take effect only while NMI enable bit 0 is 0, and the byte reads back with the mode in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 11 | Byte address within the window |
| half_i | input | 1 | 1 = halfword transfer, 0 = byte transfer |
| wr_en_i | input | 1 | One-cycle write strobe |
| rd_en_i | input | 1 | One-cycle read strobe |
| wdata_i | input | 16 | Write data, byte transfers use bits [7:0] |
| flag_i | input | NUM_SRC | Pending flags from the detect block |
| rdata_o | output | 16 | Registered read data |
| flag_clr_o | output | NUM_SRC | One-cycle flag clear request per source |
| xfer_en_o | output | NUM_SRC | Transfer-trigger enable per source |
| src_en_o | output | NUM_SRC | Request enable per source |
| prio_o | output | NUM_PRIO*4 | Priority level per group |
| fast_vec_o | output | 8 | Fast-interrupt source number |
| fast_en_o | output | 1 | Fast-interrupt enable |
| dma_src_o | output | NUM_DMA*8 | DMA start-source numbers |
| pin_mode_o | output | NUM_PIN*2 | Trigger mode per external pin |
| nmi_en_o | output | 3 | NMI source enables |
| nmi_mode_o | output | 1 | NMI pin mode |
| sw_pulse_o | output | 1 | Software interrupt pulse |

## Verification
Every configuration output is a register driven straight to a port, so a wrong stored bit shows on the matching output in the cycle right after the write that caused it. A bench comparing every cycle catches it at once, and it does not have to wait for a read. A decode or width-rule fault that changes no stored state shows on `rdata_o` one cycle after the read strobe, either as a stray 16'hFFFF or as a missing one. A fault in the strobe logic shows as an extra, missing or lengthened cycle on `sw_pulse_o` or `flag_clr_o`. The lock rules only show later. A cleared NMI enable or a mode write that got through stays visible on `nmi_en_o` or `nmi_mode_o` from the next cycle onward.

// File: rtl/icu_reg_pkg.sv
package icu_reg_pkg;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int PRIO_W = 4;

  localparam logic [ADDR_W-1:0] A_SWI     = 11'h2E0;
  localparam logic [ADDR_W-1:0] A_FAST    = 11'h2F0;
  localparam logic [ADDR_W-1:0] A_NMI_ST  = 11'h580;
  localparam logic [ADDR_W-1:0] A_NMI_EN  = 11'h581;
  localparam logic [ADDR_W-1:0] A_NMI_CLR = 11'h582;
  localparam logic [ADDR_W-1:0] A_NMI_CTL = 11'h583;

  localparam logic [DATA_W-1:0] BAD_READ = '1;

  typedef enum logic [3:0] {
    RG_NONE, RG_FLAG, RG_XFER, RG_EN, RG_SWI, RG_FAST, RG_PRIO,
    RG_DMA, RG_PIN, RG_NMI_ST, RG_NMI_EN, RG_NMI_CLR, RG_NMI_CTL
  } region_e;

  typedef struct packed {
    region_e    rg;
    logic [7:0] idx;
    logic       legal;
  } dec_t;

  // Map an address and width onto a register region and element index.
  function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                       input logic half,
                                       input int nsrc, input int nen,
                                       input int nprio, input int npin,
                                       input int ndma);
    dec_t d;
    logic [7:0] lo;
    lo      = a[7:0];
    d.rg    = RG_NONE;
    d.idx   = lo;
    d.legal = 1'b0;
    case (a[10:8])
      3'd0: if (int'(lo) < nsrc) d.rg = RG_FLAG;
      3'd1: if (int'(lo) < nsrc) d.rg = RG_XFER;
      3'd2: begin
        if (int'(lo) < nen)  d.rg = RG_EN;
        else if (a == A_SWI)  d.rg = RG_SWI;
        else if (a == A_FAST) d.rg = RG_FAST;
      end
      3'd3: if (int'(lo) < nprio) d.rg = RG_PRIO;
      3'd4: if (lo[1:0] == 2'b00 && int'(lo[7:2]) < ndma) begin
        d.rg  = RG_DMA;
        d.idx = {2'b00, lo[7:2]};
      end
      3'd5: begin
        if (int'(lo) < npin)      d.rg = RG_PIN;
        else if (a == A_NMI_ST)  d.rg = RG_NMI_ST;
        else if (a == A_NMI_EN)  d.rg = RG_NMI_EN;
        else if (a == A_NMI_CLR) d.rg = RG_NMI_CLR;
        else if (a == A_NMI_CTL) d.rg = RG_NMI_CTL;
      end
      default: d.rg = RG_NONE;
    endcase
    d.legal = (d.rg != RG_NONE) && ((d.rg == RG_FAST) == half);
    return d;
  endfunction

  // Trigger mode field taken from a pin control write.
  function automatic logic [1:0] pin_mode_of(input logic [7:0] v);
    return v[3:2];
  endfunction

  // Pin control read image.
  function automatic logic [7:0] pin_image(input logic [1:0] m);
    return {4'b0000, m, 2'b00};
  endfunction

  // Fast interrupt read image: enable in bit 15, vector in [7:0].
  function automatic logic [DATA_W-1:0] fast_image(input logic en,
                                                   input logic [7:0] vec);
    return {en, 7'b0000000, vec};
  endfunction

endpackage

// File: rtl/icu_addr_decode.sv
module icu_addr_decode
  import icu_reg_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_PRIO = 144,
  parameter int NUM_PIN  = 32,
  parameter int NUM_DMA  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_i,
  output region_e           rg_o,
  output logic [7:0]        idx_o,
  output logic              legal_o
);
  localparam int EN_BYTES = NUM_SRC / 8;

  dec_t dec;

  always_comb begin
    dec     = decode_addr(addr_i, half_i, NUM_SRC, EN_BYTES, NUM_PRIO,
                          NUM_PIN, NUM_DMA);
    rg_o    = dec.rg;
    idx_o   = dec.idx;
    legal_o = dec.legal;
  end
endmodule

// File: rtl/icu_src_cfg.sv
module icu_src_cfg
  import icu_reg_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_PRIO = 144,
  parameter int NUM_PIN  = 32,
  parameter int NUM_DMA  = 4,
  parameter logic [1:0] PIN_RST = 2'b10
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic                       wr_i,
  input  region_e                    rg_i,
  input  logic [7:0]                 idx_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_SRC-1:0]         flag_i,
  output logic [DATA_W-1:0]          rd_o,
  output logic [NUM_SRC-1:0]         flag_clr_o,
  output logic [NUM_SRC-1:0]         xfer_en_o,
  output logic [NUM_SRC-1:0]         src_en_o,
  output logic [NUM_PRIO*PRIO_W-1:0] prio_o,
  output logic [7:0]                 fast_vec_o,
  output logic                       fast_en_o,
  output logic [NUM_DMA*8-1:0]       dma_src_o,
  output logic [NUM_PIN*2-1:0]       pin_mode_o
);
  localparam int EN_BYTES = NUM_SRC / 8;
  localparam int SRC_AW   = (NUM_SRC  > 1) ? $clog2(NUM_SRC)  : 1;
  localparam int EN_AW    = (EN_BYTES > 1) ? $clog2(EN_BYTES) : 1;
  localparam int PRIO_AW  = (NUM_PRIO > 1) ? $clog2(NUM_PRIO) : 1;
  localparam int PIN_AW   = (NUM_PIN  > 1) ? $clog2(NUM_PIN)  : 1;
  localparam int DMA_AW   = (NUM_DMA  > 1) ? $clog2(NUM_DMA)  : 1;

  logic [NUM_SRC-1:0] xfer_q;
  logic [NUM_SRC-1:0] clr_q;
  logic [7:0]         en_q   [EN_BYTES];
  logic [PRIO_W-1:0]  prio_q [NUM_PRIO];
  logic [7:0]         dma_q  [NUM_DMA];
  logic [1:0]         pin_q  [NUM_PIN];
  logic [7:0]         fvec_q;
  logic               fen_q;
  logic               unused_wbits;

  wire [SRC_AW-1:0]  src_ix  = idx_i[SRC_AW-1:0];
  wire [EN_AW-1:0]   en_ix   = idx_i[EN_AW-1:0];
  wire [PRIO_AW-1:0] prio_ix = idx_i[PRIO_AW-1:0];
  wire [PIN_AW-1:0]  pin_ix  = idx_i[PIN_AW-1:0];
  wire [DMA_AW-1:0]  dma_ix  = idx_i[DMA_AW-1:0];

  // Named write events for the checks below.
  wire flag_zero_wr = wr_i && (rg_i == RG_FLAG) && (wdata_i[7:0] == 8'h00);

  assign unused_wbits = ^wdata_i[14:8];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      xfer_q <= '0;
      clr_q  <= '0;
      fvec_q <= '0;
      fen_q  <= 1'b0;
      for (int i = 0; i < EN_BYTES; i++) en_q[i]   <= '0;
      for (int i = 0; i < NUM_PRIO; i++) prio_q[i] <= '0;
      for (int i = 0; i < NUM_DMA;  i++) dma_q[i]  <= '0;
      for (int i = 0; i < NUM_PIN;  i++) pin_q[i]  <= PIN_RST;
    end else begin
      clr_q <= '0;
      if (flag_zero_wr) clr_q[src_ix] <= 1'b1;
      if (wr_i) begin
        case (rg_i)
          RG_XFER: xfer_q[src_ix]  <= wdata_i[0];
          RG_EN:   en_q[en_ix]     <= wdata_i[7:0];
          RG_PRIO: prio_q[prio_ix] <= wdata_i[PRIO_W-1:0];
          RG_DMA:  dma_q[dma_ix]   <= wdata_i[7:0];
          RG_PIN:  pin_q[pin_ix]   <= pin_mode_of(wdata_i[7:0]);
          RG_FAST: begin
            fvec_q <= wdata_i[7:0];
            fen_q  <= wdata_i[15];
          end
          default: ;
        endcase
      end
    end
  end

  // Flatten the arrays onto the configuration ports.
  genvar g;
  generate
    for (g = 0; g < EN_BYTES; g++) begin : g_en
      assign src_en_o[g*8 +: 8] = en_q[g];
    end
    for (g = 0; g < NUM_PRIO; g++) begin : g_prio
      assign prio_o[g*PRIO_W +: PRIO_W] = prio_q[g];
    end
    for (g = 0; g < NUM_DMA; g++) begin : g_dma
      assign dma_src_o[g*8 +: 8] = dma_q[g];
    end
    for (g = 0; g < NUM_PIN; g++) begin : g_pin
      assign pin_mode_o[g*2 +: 2] = pin_q[g];
    end
  endgenerate

  assign flag_clr_o = clr_q;
  assign xfer_en_o  = xfer_q;
  assign fast_vec_o = fvec_q;
  assign fast_en_o  = fen_q;

  always_comb begin
    rd_o = '0;
    case (rg_i)
      RG_FLAG: rd_o[0]        = flag_i[src_ix];
      RG_XFER: rd_o[0]        = xfer_q[src_ix];
      RG_EN:   rd_o[7:0]      = en_q[en_ix];
      RG_PRIO: rd_o[PRIO_W-1:0] = prio_q[prio_ix];
      RG_DMA:  rd_o[7:0]      = dma_q[dma_ix];
      RG_PIN:  rd_o[7:0]      = pin_image(pin_q[pin_ix]);
      RG_FAST: rd_o           = fast_image(fen_q, fvec_q);
      default: rd_o           = '0;
    endcase
  end

  // R7
  clr_from_zero_wr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|clr_q) |-> $past(flag_zero_wr));

  // R5
  en_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(wr_i) && !$past(rst_i)) |-> $stable(src_en_o));

  // R8
  prio_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(wr_i) && !$past(rst_i)) |-> $stable(prio_o));
endmodule

// File: rtl/icu_nmi_swi.sv
module icu_nmi_swi
  import icu_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  region_e           rg_i,
  input  logic [3:0]        wbits_i,
  output logic [DATA_W-1:0] rd_o,
  output logic [2:0]        nmi_en_o,
  output logic              nmi_mode_o,
  output logic              sw_pulse_o
);
  logic [2:0] nmi_en_q;
  logic       nmi_mode_q;
  logic       pulse_q;

  wire mode_locked = nmi_en_q[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      nmi_en_q   <= '0;
      nmi_mode_q <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      pulse_q <= wr_i && (rg_i == RG_SWI) && wbits_i[0];
      if (wr_i && rg_i == RG_NMI_EN)
        nmi_en_q <= nmi_en_q | wbits_i[2:0];
      if (wr_i && rg_i == RG_NMI_CTL && !mode_locked)
        nmi_mode_q <= wbits_i[3];
    end
  end

  always_comb begin
    rd_o = '0;
    case (rg_i)
      RG_NMI_EN:  rd_o[2:0] = nmi_en_q;
      RG_NMI_CTL: rd_o[3]   = nmi_mode_q;
      default:    rd_o      = '0;
    endcase
  end

  assign nmi_en_o   = nmi_en_q;
  assign nmi_mode_o = nmi_mode_q;
  assign sw_pulse_o = pulse_q;

  // R13
  nmi_set_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (($past(nmi_en_q) & ~nmi_en_q) == 3'b000));

  // R14
  nmi_mode_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(nmi_en_q[0]) && !$past(rst_i)) |-> $stable(nmi_mode_q));
endmodule

// File: rtl/icu_reg_if.sv
module icu_reg_if
  import icu_reg_pkg::*;
#(
  parameter int NUM_SRC  = 256,
  parameter int NUM_PRIO = 144,
  parameter int NUM_PIN  = 32,
  parameter int NUM_DMA  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_i,
  input  logic [10:0]                addr_i,
  input  logic                       half_i,
  input  logic                       wr_en_i,
  input  logic                       rd_en_i,
  input  logic [15:0]                wdata_i,
  input  logic [NUM_SRC-1:0]         flag_i,
  output logic [15:0]                rdata_o,
  output logic [NUM_SRC-1:0]         flag_clr_o,
  output logic [NUM_SRC-1:0]         xfer_en_o,
  output logic [NUM_SRC-1:0]         src_en_o,
  output logic [NUM_PRIO*4-1:0]      prio_o,
  output logic [7:0]                 fast_vec_o,
  output logic                       fast_en_o,
  output logic [NUM_DMA*8-1:0]       dma_src_o,
  output logic [NUM_PIN*2-1:0]       pin_mode_o,
  output logic [2:0]                 nmi_en_o,
  output logic                       nmi_mode_o,
  output logic                       sw_pulse_o
);
  region_e           dec_rg;
  logic [7:0]        dec_idx;
  logic              dec_legal;
  logic [DATA_W-1:0] cfg_rd;
  logic [DATA_W-1:0] nmi_rd;
  logic [DATA_W-1:0] rdata_q;

  // Named access events.
  wire wr_hit = wr_en_i && dec_legal;
  wire rd_bad = rd_en_i && !dec_legal;

  icu_addr_decode #(
    .NUM_SRC(NUM_SRC), .NUM_PRIO(NUM_PRIO), .NUM_PIN(NUM_PIN), .NUM_DMA(NUM_DMA)
  ) i_dec (
    .addr_i  (addr_i),
    .half_i  (half_i),
    .rg_o    (dec_rg),
    .idx_o   (dec_idx),
    .legal_o (dec_legal)
  );

  icu_src_cfg #(
    .NUM_SRC(NUM_SRC), .NUM_PRIO(NUM_PRIO), .NUM_PIN(NUM_PIN), .NUM_DMA(NUM_DMA)
  ) i_cfg (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_i       (wr_hit),
    .rg_i       (dec_rg),
    .idx_i      (dec_idx),
    .wdata_i    (wdata_i),
    .flag_i     (flag_i),
    .rd_o       (cfg_rd),
    .flag_clr_o (flag_clr_o),
    .xfer_en_o  (xfer_en_o),
    .src_en_o   (src_en_o),
    .prio_o     (prio_o),
    .fast_vec_o (fast_vec_o),
    .fast_en_o  (fast_en_o),
    .dma_src_o  (dma_src_o),
    .pin_mode_o (pin_mode_o)
  );

  icu_nmi_swi i_nmi (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .wr_i       (wr_hit),
    .rg_i       (dec_rg),
    .wbits_i    (wdata_i[3:0]),
    .rd_o       (nmi_rd),
    .nmi_en_o   (nmi_en_o),
    .nmi_mode_o (nmi_mode_o),
    .sw_pulse_o (sw_pulse_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_bad)  rdata_q <= BAD_READ;
    else if (rd_en_i) rdata_q <= cfg_rd | nmi_rd;
  end

  assign rdata_o = rdata_q;

  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(rd_en_i) && !$past(rst_i)) |-> $stable(rdata_o));

  // R3
  bad_read_ones_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rd_en_i && !dec_legal && !rst_i) |-> (rdata_o == 16'hFFFF));

  // R12
  swi_pulse_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    sw_pulse_o |-> $past(wr_en_i && !half_i && addr_i == A_SWI && wdata_i[0]));

  // R1
  reset_cfg_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (nmi_en_o == 3'b000 && !fast_en_o && rdata_o == 16'h0000));
endmodule

// File: tb/test_icu_reg_if.sv
`timescale 1ns/1ps
module test_icu_reg_if;
  localparam int NS = 256, NP = 144, NPIN = 32, ND = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [10:0]     addr;
  logic            half, wr, rd;
  logic [15:0]     wdata;
  logic [NS-1:0]   flag_in;
  logic [15:0]     rdata_o;
  logic [NS-1:0]   flag_clr_o, xfer_en_o, src_en_o;
  logic [NP*4-1:0] prio_o;
  logic [7:0]      fast_vec_o;
  logic            fast_en_o;
  logic [ND*8-1:0] dma_src_o;
  logic [NPIN*2-1:0] pin_mode_o;
  logic [2:0]      nmi_en_o;
  logic            nmi_mode_o, sw_pulse_o;

  int compared = 0;
  int mismatched = 0;
  bit running = 0;

  always #2.5 clk = ~clk;

  icu_reg_if i_icu_reg_if (
    .clk_i(clk), .rst_i(rst), .addr_i(addr), .half_i(half), .wr_en_i(wr),
    .rd_en_i(rd), .wdata_i(wdata), .flag_i(flag_in), .rdata_o(rdata_o),
    .flag_clr_o(flag_clr_o), .xfer_en_o(xfer_en_o), .src_en_o(src_en_o),
    .prio_o(prio_o), .fast_vec_o(fast_vec_o), .fast_en_o(fast_en_o),
    .dma_src_o(dma_src_o), .pin_mode_o(pin_mode_o), .nmi_en_o(nmi_en_o),
    .nmi_mode_o(nmi_mode_o), .sw_pulse_o(sw_pulse_o)
  );

  // Behavioural reference state
  bit [7:0]  m_en [32];
  bit        m_xf [256];
  bit [3:0]  m_pr [144];
  bit [7:0]  m_dm [4];
  bit [1:0]  m_pn [32];
  bit [15:0] m_fast;
  bit [2:0]  m_ne;
  bit        m_nm;
  bit [15:0] m_rd;
  bit        m_sw;
  int        m_clr;

  function automatic bit [15:0] ref_read(int a, bit h);
    if (h) return (a == 'h2F0) ? m_fast : 16'hFFFF;
    if (a < 'h100) return {15'b0, flag_in[a]};
    if (a < 'h200) return {15'b0, m_xf[a - 'h100]};
    if (a < 'h220) return {8'b0, m_en[a - 'h200]};
    if (a == 'h2E0) return 16'h0000;
    if (a >= 'h300 && a < 'h390) return {12'b0, m_pr[a - 'h300]};
    if (a >= 'h400 && a < 'h410 && a % 4 == 0) return {8'b0, m_dm[(a - 'h400) / 4]};
    if (a >= 'h500 && a < 'h520) return {12'b0, m_pn[a - 'h500], 2'b00};
    if (a == 'h580 || a == 'h582) return 16'h0000;
    if (a == 'h581) return {13'b0, m_ne};
    if (a == 'h583) return {12'b0, m_nm, 3'b000};
    return 16'hFFFF;
  endfunction

  function automatic void ref_write(int a, bit h, bit [15:0] d);
    if (h) begin
      if (a == 'h2F0) m_fast = d & 16'h80FF;
      return;
    end
    if (a < 'h100) begin
      if (d[7:0] == 8'h00) m_clr = a;
    end
    else if (a < 'h200) m_xf[a - 'h100] = d[0];
    else if (a < 'h220) m_en[a - 'h200] = d[7:0];
    else if (a == 'h2E0) m_sw = d[0];
    else if (a >= 'h300 && a < 'h390) m_pr[a - 'h300] = d[3:0];
    else if (a >= 'h400 && a < 'h410 && a % 4 == 0) m_dm[(a - 'h400) / 4] = d[7:0];
    else if (a >= 'h500 && a < 'h520) m_pn[a - 'h500] = d[3:2];
    else if (a == 'h581) m_ne = m_ne | d[2:0];
    else if (a == 'h583 && !m_ne[0]) m_nm = d[3];
  endfunction

  always @(posedge clk) begin
    m_sw  = 1'b0;
    m_clr = -1;
    if (rst) begin
      foreach (m_en[i]) m_en[i] = '0;
      foreach (m_xf[i]) m_xf[i] = '0;
      foreach (m_pr[i]) m_pr[i] = '0;
      foreach (m_dm[i]) m_dm[i] = '0;
      foreach (m_pn[i]) m_pn[i] = 2'b10;
      m_fast = '0; m_ne = '0; m_nm = 1'b0; m_rd = '0;
    end else begin
      if (rd) m_rd = ref_read(int'(addr), half);
      if (wr) ref_write(int'(addr), half, wdata);
    end
  end

  task automatic chk(input logic [575:0] act, input logic [575:0] exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  logic [NS-1:0]     e_clr, e_xf, e_en;
  logic [NP*4-1:0]   e_pr;
  logic [ND*8-1:0]   e_dm;
  logic [NPIN*2-1:0] e_pn;

  // Whole-state comparison on every clock
  always @(negedge clk) begin
    if (running && !rst) begin
      e_clr = '0;
      if (m_clr >= 0) e_clr[m_clr] = 1'b1;
      for (int i = 0; i < NS; i++) begin
        e_xf[i] = m_xf[i];
        e_en[i] = m_en[i/8][i%8];
      end
      for (int i = 0; i < NP; i++) e_pr[i*4 +: 4] = m_pr[i];
      for (int i = 0; i < ND; i++) e_dm[i*8 +: 8] = m_dm[i];
      for (int i = 0; i < NPIN; i++) e_pn[i*2 +: 2] = m_pn[i];
      chk(576'(rdata_o), 576'(m_rd), "R2 read data");
      chk(576'(sw_pulse_o), 576'(m_sw), "R12 sw pulse");
      chk(576'(flag_clr_o), 576'(e_clr), "R7 flag clear");
      chk(576'(xfer_en_o), 576'(e_xf), "R6 transfer enables");
      chk(576'(src_en_o), 576'(e_en), "R5 request enables");
      chk(576'(prio_o), 576'(e_pr), "R8 priorities");
      chk(576'({fast_en_o, fast_vec_o}), 576'({m_fast[15], m_fast[7:0]}), "R9 fast interrupt");
      chk(576'(dma_src_o), 576'(e_dm), "R10 dma sources");
      chk(576'(pin_mode_o), 576'(e_pn), "R11 pin modes");
      chk(576'(nmi_en_o), 576'(m_ne), "R13 nmi enables");
      chk(576'(nmi_mode_o), 576'(m_nm), "R14 nmi mode");
    end
  end

  task automatic bus_wr(input int a, input bit h, input bit [15:0] d);
    addr = 11'(a); half = h; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input int a, input bit h);
    addr = 11'(a); half = h; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic expect_rd(input int a, input bit h, input bit [15:0] exp, input string tag);
    bus_rd(a, h);
    chk(576'(rdata_o), 576'(exp), tag);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; addr = '0; half = 1'b0; wr = 1'b0; rd = 1'b0; wdata = '0;
    flag_in = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    running = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(576'(src_en_o), 576'(0), "R1 enables after reset");
    chk(576'(pin_mode_o), 576'({32{2'b10}}), "R1 pin modes after reset");
    chk(576'({nmi_en_o, nmi_mode_o, fast_en_o}), 576'(0), "R1 nmi/fast after reset");
    chk(576'(rdata_o), 576'(0), "R1 rdata after reset");

    // R5
    bus_wr('h205, 0, 16'h00A5);
    chk(576'(src_en_o[47:40]), 576'(8'hA5), "R5 enable byte on port");
    expect_rd('h205, 0, 16'h00A5, "R5 enable readback");
    // R2 hold
    repeat (3) @(negedge clk);
    chk(576'(rdata_o), 576'(16'h00A5), "R2 rdata held");
    // R6
    bus_wr('h10A, 0, 16'h00FF);
    expect_rd('h10A, 0, 16'h0001, "R6 transfer enable bit0 only");
    flag_in[3] = 1'b1;
    expect_rd('h003, 0, 16'h0001, "R6 flag read");
    expect_rd('h004, 0, 16'h0000, "R6 flag read clear");
    // R8 / R4
    bus_wr('h38F, 0, 16'h00FE);
    expect_rd('h38F, 0, 16'h000E, "R8 priority low nibble");
    expect_rd('h390, 0, 16'hFFFF, "R4 past priority range");
    // R9 / R3
    bus_wr('h2F0, 1, 16'hFFFF);
    expect_rd('h2F0, 1, 16'h80FF, "R9 fast readback");
    expect_rd('h2F0, 0, 16'hFFFF, "R3 byte read of fast reg");
    bus_wr('h2F0, 0, 16'h0000);
    expect_rd('h2F0, 1, 16'h80FF, "R3 byte write to fast reg dropped");
    expect_rd('h200, 1, 16'hFFFF, "R3 half read of enable");
    bus_wr('h201, 1, 16'h1234);
    expect_rd('h201, 0, 16'h0000, "R3 half write to enable dropped");
    // R10
    bus_wr('h404, 0, 16'h005A);
    expect_rd('h404, 0, 16'h005A, "R10 dma readback");
    bus_wr('h405, 0, 16'h0011);
    expect_rd('h405, 0, 16'hFFFF, "R4 unaligned dma offset");
    expect_rd('h404, 0, 16'h005A, "R10 dma kept after hole write");
    // R11
    expect_rd('h500, 0, 16'h0008, "R11 reset mode rising");
    bus_wr('h507, 0, 16'h000C);
    chk(576'(pin_mode_o[15:14]), 576'(2'b11), "R11 pin 7 both edges");
    expect_rd('h507, 0, 16'h000C, "R11 readback");
    // R12
    bus_wr('h2E0, 0, 16'h0001);
    chk(576'(sw_pulse_o), 576'(1), "R12 pulse high");
    @(negedge clk);
    chk(576'(sw_pulse_o), 576'(0), "R12 pulse one cycle");
    expect_rd('h2E0, 0, 16'h0000, "R12 reads zero");
    // R7
    bus_wr('h010, 0, 16'h0000);
    chk(576'(flag_clr_o), 576'(256'(1) << 16), "R7 clear strobe");
    bus_wr('h010, 0, 16'h0001);
    chk(576'(flag_clr_o), 576'(0), "R7 nonzero write no strobe");
    // R14 before lock
    bus_wr('h583, 0, 16'h0008);
    expect_rd('h583, 0, 16'h0008, "R14 mode written while unlocked");
    // R13
    bus_wr('h581, 0, 16'h0005);
    bus_wr('h581, 0, 16'h0002);
    expect_rd('h581, 0, 16'h0007, "R13 enables OR");
    bus_wr('h581, 0, 16'h0000);
    expect_rd('h581, 0, 16'h0007, "R13 no clear");
    expect_rd('h580, 0, 16'h0000, "R13 status reads zero");
    bus_wr('h582, 0, 16'h00FF);
    expect_rd('h582, 0, 16'h0000, "R13 clear reads zero");
    // R14 locked
    bus_wr('h583, 0, 16'h0000);
    expect_rd('h583, 0, 16'h0008, "R14 mode locked");
    // R4
    expect_rd('h7FF, 0, 16'hFFFF, "R4 beyond window");
    bus_wr('h600, 0, 16'h00FF);
    expect_rd('h230, 0, 16'hFFFF, "R4 hole after enables");

    // Mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      int a;
      case ($urandom % 11)
        0: a = $urandom % 256;
        1: a = 'h100 + $urandom % 256;
        2: a = 'h200 + $urandom % 40;
        3: a = 'h2E0;
        4: a = 'h2F0 + $urandom % 2;
        5: a = 'h300 + $urandom % 150;
        6: a = 'h400 + $urandom % 16;
        7: a = 'h500 + $urandom % 36;
        8: a = 'h580 + $urandom % 4;
        9: a = $urandom % 2048;
        default: a = 'h583;
      endcase
      if ($urandom % 16 == 0) flag_in = {8{$urandom}};
      addr  = 11'(a);
      half  = ($urandom % 8 == 0);
      wdata = 16'($urandom);
      if ($urandom % 4 == 0) wdata[7:0] = 8'h00;
      wr    = ($urandom % 2 == 0);
      rd    = ($urandom % 2 == 0);
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      if ($urandom % 4 == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule